// File: doc/BRIEF.md
# Run-Time Sized In-Place FFT Address Sequencer

This block sequences a radix-2 decimation-in-time FFT that reuses one butterfly unit for every butterfly and writes each result back over its own inputs. After a start pulse it walks the stages of the transform in order. Each cycle of a stage it issues one butterfly: a read strobe, the two data addresses of that butterfly and the twiddle index that goes with them. The same two addresses come back out as write addresses once the butterfly pipeline has produced the results, so the butterflies of a stage stream one per cycle with no gaps.

The transform length is chosen per run by a 3-bit size code, from 8 to 1024 points. The data memory is held in two narrow banks (real part and imaginary part) that sit side by side. Both banks take the same address pair and the same strobes, so the sequencer drives one pair of addresses for both. The twiddle index always addresses a cosine/sine table built for the largest length, so the index is already scaled for shorter transforms. Before a stage starts reading, the sequencer waits until the last result of the previous stage has been written back. When the final write is done, it gives a one-cycle done pulse.

Top module: `fftAddrGen`

## Requirements
- R1: The size code c (0..7) selects a length of N = 8·2^c points and L = c+3 stages. The code is latched when start is accepted, and a run issues exactly L·N/2 reads.
- R2: In stage s (0-based, ascending), butterfly j runs from 0 to N/2−1 in ascending order, one per cycle with rdEn high. rdAddrA is j with a 0 inserted at bit s, and rdAddrB = rdAddrA + 2^s.
- R3: In the same cycle as each read, twIdx = (j mod 2^s)·2^(9−s), an index into a 1024-point table. It is 0 in stage 0.
- R4: wrEn, wrAddrA and wrAddrB equal rdEn, rdAddrA and rdAddrB delayed by exactly LAT cycles.
- R5: The first read of stage s+1 comes LAT+1 cycles after the last read of stage s. No read of a new stage happens while writes of the previous stage are pending.
- R6: A start sampled while idle begins the run. In the next cycle busy is high, rdEn is high and the addresses are 0 and 1.
- R7: A start while busy is ignored, even with a different size code. The run in progress keeps its length and sequence.
- R8: busy stays high for L·(N/2+LAT) cycles. done is high for exactly one cycle, the cycle after the final write, and busy is low in that cycle. A start in the done cycle is accepted.
- R9: With the default LAT=4, a 256-point run lasts 1056 cycles from start to done, within the 2063-cycle budget.
- R10: While reset is asserted, rdEn, wrEn, busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; honoured only while idle |
| sizeCode | input | 3 | Length select, N = 8·2^code |
| rdEn | output | 1 | Read strobe for both data banks |
| rdAddrA | output | 10 | Upper-leg read address (lower index) |
| rdAddrB | output | 10 | Lower-leg read address (index + span) |
| twIdx | output | 9 | Twiddle index into the 1024-point table |
| wrEn | output | 1 | Write strobe for both data banks |
| wrAddrA | output | 10 | Write address for the first result |
| wrAddrB | output | 10 | Write address for the second result |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
A start sampled at a clock edge shows up as a read in the cycle right after that edge. The write of the same butterfly follows exactly LAT cycles later. done comes L·(N/2+LAT) cycles after the start edge. A behavioural model in the bench counts cycles from the accepted start and works out which read, write, busy and done values each cycle must carry. The bench compares the design's outputs with those values at every falling edge, where all registered outputs have settled. Explicit checks count reads and busy cycles per run, look at the first cycle after start, and cover a start in the done cycle.

// File: rtl/fftAgPkg.sv
package fftAgPkg;
  localparam int AG_MAX_LOG2 = 10;
  localparam int AG_MIN_LOG2 = 3;
  localparam int SIZE_W  = 3;
  localparam int STAGE_W = $clog2(AG_MAX_LOG2 + 1);
  localparam int ADDR_W  = AG_MAX_LOG2;
  localparam int BFLY_W  = AG_MAX_LOG2 - 1;
  localparam int TW_W    = AG_MAX_LOG2 - 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT} agState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic               issue;
    logic [STAGE_W-1:0] stage;
    logic [BFLY_W-1:0]  bfly;
    logic [STAGE_W-1:0] log2n;
  } agCmd_t;

  typedef struct packed {
    logic              v;
    logic [ADDR_W-1:0] a;
    logic [ADDR_W-1:0] b;
  } wrSlot_t;
endpackage

// File: rtl/fftAgCtrl.sv
module fftAgCtrl
  import fftAgPkg::*;
#(
  parameter int LAT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [SIZE_W-1:0] sizeCode,
  output agCmd_t            cmd,
  output logic              busy,
  output logic              done
);
  localparam int WCW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [WCW-1:0] WAIT_LAST = WCW'(LAT - 1);

  agState_e           state;
  logic [STAGE_W-1:0] stage;
  logic [STAGE_W-1:0] log2n;
  logic [BFLY_W-1:0]  bfly;
  logic [BFLY_W-1:0]  lastBfly;
  logic [WCW-1:0]     waitCnt;
  logic               lastStage;

  assign lastBfly  = BFLY_W'((32'd1 << (log2n - STAGE_W'(1))) - 32'd1);
  assign lastStage = (stage == log2n - STAGE_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stage   <= '0;
      log2n   <= '0;
      bfly    <= '0;
      waitCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            log2n <= STAGE_W'(sizeCode) + STAGE_W'(AG_MIN_LOG2);
            stage <= '0;
            bfly  <= '0;
            state <= S_RUN;
          end
        end
        S_RUN: begin
          if (bfly == lastBfly) begin
            bfly    <= '0;
            waitCnt <= '0;
            state   <= S_WAIT;
          end else begin
            bfly <= bfly + BFLY_W'(1);
          end
        end
        S_WAIT: begin
          if (waitCnt == WAIT_LAST) begin
            if (lastStage) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else begin
              stage <= stage + STAGE_W'(1);
              state <= S_RUN;
            end
          end else begin
            waitCnt <= waitCnt + WCW'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign cmd.issue = (state == S_RUN);
  assign cmd.stage = stage;
  assign cmd.bfly  = bfly;
  assign cmd.log2n = log2n;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy); // R8
  AST_SIZE_HELD: assert property (@(posedge clk) disable iff (!rstN) (busy && $past(busy)) |-> $stable(log2n)); // R7
  AST_SIZE_RANGE: assert property (@(posedge clk) disable iff (!rstN) busy |-> (log2n >= STAGE_W'(AG_MIN_LOG2) && log2n <= STAGE_W'(AG_MAX_LOG2))); // R1
endmodule

// File: rtl/fftAgDatapath.sv
module fftAgDatapath
  import fftAgPkg::*;
#(
  parameter int LAT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  agCmd_t            cmd,
  output logic              rdEn,
  output logic [ADDR_W-1:0] rdAddrA,
  output logic [ADDR_W-1:0] rdAddrB,
  output logic [TW_W-1:0]   twIdx,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddrA,
  output logic [ADDR_W-1:0] wrAddrB
);
  logic [BFLY_W-1:0] lowMask;
  logic [BFLY_W-1:0] lowBits;
  logic [BFLY_W-1:0] highBits;
  logic [31:0]       twWide;
  wrSlot_t           cur;
  wrSlot_t           pipe [LAT];

  assign lowMask  = BFLY_W'((32'd1 << cmd.stage) - 32'd1);
  assign lowBits  = cmd.bfly & lowMask;
  assign highBits = cmd.bfly & ~lowMask;
  assign rdEn     = cmd.issue;
  assign rdAddrA  = {highBits, 1'b0} | {1'b0, lowBits};
  assign rdAddrB  = rdAddrA | ADDR_W'(32'd1 << cmd.stage);
  assign twWide   = 32'(lowBits) << (32'(BFLY_W) - 32'(cmd.stage));
  assign twIdx    = twWide[TW_W-1:0];

  assign cur.v = rdEn;
  assign cur.a = rdAddrA;
  assign cur.b = rdAddrB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LAT; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= cur;
      for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign wrEn    = pipe[LAT-1].v;
  assign wrAddrA = pipe[LAT-1].a;
  assign wrAddrB = pipe[LAT-1].b;

  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN) rdEn |-> ({1'b0, rdAddrB} < (11'd1 << cmd.log2n))); // R2
  AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rstN) rdEn |-> (rdAddrA < rdAddrB)); // R2
  AST_TW_STAGE0: assert property (@(posedge clk) disable iff (!rstN) (rdEn && cmd.stage == '0) |-> (twIdx == '0)); // R3
  AST_WR_PAIR_SPAN: assert property (@(posedge clk) disable iff (!rstN) wrEn |-> ($countones(wrAddrA ^ wrAddrB) == 1)); // R4
endmodule

// File: rtl/fftAddrGen.sv
module fftAddrGen
  import fftAgPkg::*;
#(
  parameter int LAT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [SIZE_W-1:0] sizeCode,
  output logic              rdEn,
  output logic [ADDR_W-1:0] rdAddrA,
  output logic [ADDR_W-1:0] rdAddrB,
  output logic [TW_W-1:0]   twIdx,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddrA,
  output logic [ADDR_W-1:0] wrAddrB,
  output logic              busy,
  output logic              done
);
  agCmd_t cmd;

  fftAgCtrl #(.LAT(LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .sizeCode(sizeCode),
    .cmd(cmd), .busy(busy), .done(done)
  );

  fftAgDatapath #(.LAT(LAT)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .rdEn(rdEn), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .twIdx(twIdx),
    .wrEn(wrEn), .wrAddrA(wrAddrA), .wrAddrB(wrAddrB)
  );
endmodule

// File: tb/fftAddrGen_tb.sv
module fftAddrGen_tb;
  localparam int LAT = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0] sizeCode = '0;
  logic rdEn, wrEn, busy, done;
  logic [9:0] rdAddrA, rdAddrB, wrAddrA, wrAddrB;
  logic [8:0] twIdx;

  int checks = 0;
  int errors = 0;
  int wd = 0;

  // model state
  bit mBusy = 0;
  bit mDone = 0;
  int mCyc = 0;
  int mL = 3;
  int mT = 0;

  always #10 clk = ~clk;

  fftAddrGen #(.LAT(LAT)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .sizeCode(sizeCode),
    .rdEn(rdEn), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .twIdx(twIdx),
    .wrEn(wrEn), .wrAddrA(wrAddrA), .wrAddrB(wrAddrB),
    .busy(busy), .done(done)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected read of the run at cycle t: returns 1 if a read occurs
  function automatic bit expRead(int l, int t, output int aA, output int aB,
                                 output int tw, output bit gap);
    int half, blk, s, j;
    half = 1 << (l - 1);
    blk  = half + LAT;
    aA = 0; aB = 0; tw = 0; gap = 0;
    if (t < 0) return 0;
    s = t / blk;
    j = t % blk;
    if (s >= l) return 0;
    if (j >= half) begin gap = 1; return 0; end
    aA = ((j >> s) << (s + 1)) + (j % (1 << s));
    aB = aA + (1 << s);
    tw = (j % (1 << s)) * (1 << (9 - s));
    return 1;
  endfunction

  // reference model advances at each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mCyc = 0;
    end else if (mBusy) begin
      mCyc++;
      if (mCyc == mT) begin mBusy = 0; mDone = 1; end
    end else begin
      mDone = 0;
      if (start) begin
        mBusy = 1; mCyc = 0;
        mL = int'(sizeCode) + 3;
        mT = mL * ((1 << (mL - 1)) + LAT);
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    int aA, aB, tw, wA, wB;
    bit rdE, wrE, gap, g2;
    if (rstN) begin
      rdE = 0; wrE = 0; gap = 0;
      aA = 0; aB = 0; tw = 0; wA = 0; wB = 0;
      if (mBusy) begin
        rdE = expRead(mL, mCyc, aA, aB, tw, gap);
        wrE = expRead(mL, mCyc - LAT, wA, wB, tw, g2);
        void'(expRead(mL, mCyc, aA, aB, tw, g2));
      end
      check("R8", "busy", int'(busy), int'(mBusy));
      check("R8", "done", int'(done), int'(mDone));
      check(gap ? "R5" : "R2", "rdEn", int'(rdEn), int'(rdE));
      if (rdE) begin
        check("R2", "rdAddrA", int'(rdAddrA), aA);
        check("R2", "rdAddrB", int'(rdAddrB), aB);
        check("R3", "twIdx", int'(twIdx), tw);
      end
      check("R4", "wrEn", int'(wrEn), int'(wrE));
      if (wrE) begin
        check("R4", "wrAddrA", int'(wrAddrA), wA);
        check("R4", "wrAddrB", int'(wrAddrB), wB);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // called at a falling edge; start is sampled at the next rising edge
  task automatic runAndMeasure(int code, bit interfere);
    int rdc, bc, l, n;
    l = code + 3;
    n = 1 << l;
    rdc = 0; bc = 0;
    start = 1'b1;
    sizeCode = 3'(code);
    @(negedge clk);
    start = 1'b0;
    check("R6", "first busy", int'(busy), 1);
    check("R6", "first rdEn", int'(rdEn), 1);
    check("R6", "first addr pair", int'(rdAddrA) * 1024 + int'(rdAddrB), 1);
    while (done !== 1'b1) begin
      if (rdEn) rdc++;
      if (busy) bc++;
      if (interfere && bc == 7) begin
        start = 1'b1;
        sizeCode = 3'(7 - code);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check("R1", "reads per run", rdc, l * n / 2);
    check(interfere ? "R7" : "R8", "busy cycles", bc, l * (n / 2 + LAT));
    if (code == 5) begin
      check("R9", "256-pt run cycles", bc, 1056);
      check("R9", "within budget", int'(bc <= 2063), 1);
    end
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      check("R10", "rdEn in reset", int'(rdEn), 0);
      check("R10", "wrEn in reset", int'(wrEn), 0);
      check("R10", "busy in reset", int'(busy), 0);
      check("R10", "done in reset", int'(done), 0);
    end
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    for (int c = 0; c < 8; c++) begin
      runAndMeasure(c, 1'b0);
      repeat (3) @(negedge clk);
    end
    // start while busy, different code: ignored
    runAndMeasure(2, 1'b1);
    repeat (2) @(negedge clk);
    runAndMeasure(0, 1'b1);
    // start in the done cycle is accepted
    runAndMeasure(1, 1'b0);
    runAndMeasure(0, 1'b0);
    repeat (LAT + 3) @(negedge clk);
    check("R8", "idle after runs", int'(busy), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule